// File: doc/BRIEF.md
# Supply Reset Release Sequencer

This block owns the chip's internal reset line and the enable of the on-chip oscillator. It watches two comparator flags that arrive already synchronized to a free-running always-on timing clock. The power flag reports that the supply is above the power-on rise threshold. The low-voltage flag reports that the supply is above the low-voltage detection level. When either cause is active, reset is held and the oscillator is stopped.

The wait before reset is released depends on which cause fired. A full power-on event waits a long stabilization-and-processing time. In low-voltage reset mode it then adds a short low-voltage processing delay. A dip below the low-voltage level alone only needs the short delay. A two-bit mode input can turn the low-voltage detector into an interrupt source that raises a one-cycle pulse and leaves reset alone. Both delays are parameters given in timing-clock cycles.

A cause output records whether the most recent reset came from the power flag or from the low-voltage flag.

Top module: `rst_release_seq`

## Requirements
- R1: While `rst_n` is low or `por_ok` is low, `rst_out` is 1 and `osc_en` is 0. After `rst_n` is released, `lvd_irq` is 0 and `cause_lvd` is 0 (power-on cause).
- R2: `osc_en` is always the inverse of `rst_out`. The oscillator runs only once reset has been released.
- R3: With `lvd_mode` = 2'b11 (low-voltage reset mode), `rst_out` falls on the clock edge that ends POR_CYCLES + LVD_CYCLES consecutive cycles with `rst_n`, `por_ok` and `lvd_ok` all high, counted from the return of the power flag or the release of `rst_n`.
- R4: With any other `lvd_mode` value, a power-on release needs only POR_CYCLES cycles with `por_ok` high.
- R5: In mode 2'b11, a fall of `lvd_ok` while running drives `rst_out` high in the same cycle, without waiting for a clock edge. Reset is released LVD_CYCLES cycles after `lvd_ok` returns high.
- R6: If `por_ok` falls during any wait, or `lvd_ok` falls during the low-voltage wait, the delay restarts from zero. The full delay is needed again after the flag returns.
- R7: `cause_lvd` is 1 after a reset caused only by the low-voltage flag and 0 after any reset in which `por_ok` fell. It does not change while reset is deasserted.
- R8: With `lvd_mode` = 2'b01, a fall of `lvd_ok` while running sets `lvd_irq` to 1 for exactly one cycle, on the next clock edge. `rst_out` stays 0.
- R9: With `lvd_mode` = 2'b00 or 2'b10, a fall of `lvd_ok` has no effect: `rst_out` stays 0 and `lvd_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running always-on timing clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| por_ok | input | 1 | Synchronized power flag, 1 when the supply is above the rise threshold |
| lvd_ok | input | 1 | Synchronized low-voltage flag, 1 when the supply is above the detection level |
| lvd_mode | input | 2 | 2'b11 low-voltage reset, 2'b01 low-voltage interrupt, other values detector ignored |
| rst_out | output | 1 | Internal reset, active high |
| osc_en | output | 1 | Oscillator enable, low for the whole reset period |
| lvd_irq | output | 1 | One-cycle low-voltage interrupt pulse |
| cause_lvd | output | 1 | Last reset cause: 1 low-voltage, 0 power-on |

## Verification
The hardest case to reach is a flag that drops again partway through a delay that is already running. The counter must clear, and the later release must still take the full delay. The stimulus drops the low-voltage flag a few cycles into its wait and the power flag about halfway through the power-on wait. It then expects the complete delay measured from the final return. A scoreboard monitor counts only cycles in which every relevant flag was good. A partial restart therefore shows up as a length mismatch.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_POR_WAIT = 2'd0,
    ST_LVD_WAIT = 2'd1,
    ST_RUN      = 2'd2
  } seq_state_e;

  typedef enum logic {
    CAUSE_POR = 1'b0,
    CAUSE_LVD = 1'b1
  } rst_cause_e;

  localparam logic [1:0] MODE_LVD_RESET = 2'b11;
  localparam logic [1:0] MODE_LVD_IRQ   = 2'b01;

endpackage

// File: rtl/rst_delay_timer.sv
module rst_delay_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] last,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = en && (cnt_q == last);

  // R6: the count never passes the terminal value of the active delay
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  // R6: a clear request returns the counter to zero on the next edge
  p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       lvd_ok,
  input  logic       lvd_rst_en,
  input  logic       tmr_done,
  output seq_state_e state_q,
  output rst_cause_e cause_q,
  output logic       tmr_clr,
  output logic       tmr_en
);

  seq_state_e state_d;
  rst_cause_e cause_d;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    if (!por_ok) begin
      state_d = ST_POR_WAIT;
      cause_d = CAUSE_POR;
    end else begin
      case (state_q)
        ST_POR_WAIT: begin
          if (tmr_done) begin
            state_d = lvd_rst_en ? ST_LVD_WAIT : ST_RUN;
          end
        end
        ST_LVD_WAIT: begin
          if (lvd_ok && tmr_done) begin
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (lvd_rst_en && !lvd_ok) begin
            state_d = ST_LVD_WAIT;
            cause_d = CAUSE_LVD;
          end
        end
        default: begin
          state_d = ST_POR_WAIT;
          cause_d = CAUSE_POR;
        end
      endcase
    end
  end

  always_comb begin
    tmr_en  = (state_q != ST_RUN);
    tmr_clr = (state_d != state_q) || !por_ok ||
              ((state_q == ST_LVD_WAIT) && !lvd_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR_WAIT;
      cause_q <= CAUSE_POR;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  // R4: the run state is entered only at the end of a timed delay
  p_run_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(tmr_done));

  // R7: a low-voltage cause is only recorded on entry from the run state
  p_cause_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q == CAUSE_LVD) |-> $past(state_q) == ST_RUN);

endmodule

// File: rtl/rst_lvd_irq.sv
module rst_lvd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic running,
  input  logic lvd_ok,
  output logic irq
);

  logic lvd_q;
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = irq_en && running && lvd_q && !lvd_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvd_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      lvd_q <= lvd_ok;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R8: the interrupt never lasts more than one cycle
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES = 1640,
  parameter int LVD_CYCLES = 51
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       lvd_ok,
  input  logic [1:0] lvd_mode,
  output logic       rst_out,
  output logic       osc_en,
  output logic       lvd_irq,
  output logic       cause_lvd
);

  localparam int MAXC = (POR_CYCLES > LVD_CYCLES) ? POR_CYCLES : LVD_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] POR_LAST = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] LVD_LAST = CW'(LVD_CYCLES - 1);

  seq_state_e    state_q;
  rst_cause_e    cause_q;
  logic          tmr_clr;
  logic          tmr_en;
  logic          tmr_done;
  logic [CW-1:0] tmr_last;
  logic          lvd_rst_en;
  logic          lvd_irq_en;

  always_comb begin
    lvd_rst_en = (lvd_mode == MODE_LVD_RESET);
    lvd_irq_en = (lvd_mode == MODE_LVD_IRQ);
    tmr_last   = (state_q == ST_LVD_WAIT) ? LVD_LAST : POR_LAST;
  end

  rst_delay_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .last  (tmr_last),
    .done  (tmr_done)
  );

  rst_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_ok     (por_ok),
    .lvd_ok     (lvd_ok),
    .lvd_rst_en (lvd_rst_en),
    .tmr_done   (tmr_done),
    .state_q    (state_q),
    .cause_q    (cause_q),
    .tmr_clr    (tmr_clr),
    .tmr_en     (tmr_en)
  );

  rst_lvd_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_en  (lvd_irq_en),
    .running (state_q == ST_RUN),
    .lvd_ok  (lvd_ok),
    .irq     (lvd_irq)
  );

  // Assertion of reset follows a falling flag at once; release waits for the registered state.
  always_comb begin
    rst_out   = !por_ok || (lvd_rst_en && !lvd_ok) || (state_q != ST_RUN);
    osc_en    = !rst_out;
    cause_lvd = (cause_q == CAUSE_LVD);
  end

  // R1: a low power flag keeps reset on into the next cycle
  p_por_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> rst_out);

  // R2: the oscillator only starts after a completed delay
  p_osc_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(tmr_done));

  // R3: release happens only with the power flag good on the releasing edge
  p_release_por_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> $past(por_ok));

  // R5: a low-voltage drop in reset mode keeps reset on into the next cycle
  p_lvd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_rst_en && !lvd_ok) |=> rst_out);

  // R7: the recorded cause is frozen while running
  p_cause_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out && $past(!rst_out)) |-> $stable(cause_lvd));

  // R8: an interrupt pulse comes without a reset
  p_irq_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_irq && por_ok && !lvd_rst_en) |-> !rst_out);

  // R9: with the detector ignored, a running chip stays out of reset while power holds
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvd_rst_en && por_ok && $past(por_ok) && $past(!rst_out)) |-> !rst_out);

endmodule

// File: tb/rst_release_seq_tb_top.sv
module rst_release_seq_tb_top;

  localparam int POR_C = 20;
  localparam int LVD_C = 6;

  logic       clk;
  logic       rst_n;
  logic       por_ok;
  logic       lvd_ok;
  logic [1:0] lvd_mode;
  logic       rst_out;
  logic       osc_en;
  logic       lvd_irq;
  logic       cause_lvd;

  int checks;
  int failures;

  typedef struct {
    int    len;
    int    cause;
    string req;
  } exp_t;

  exp_t exp_q[$];

  rst_release_seq #(.POR_CYCLES(POR_C), .LVD_CYCLES(LVD_C)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_ok    (por_ok),
    .lvd_ok    (lvd_ok),
    .lvd_mode  (lvd_mode),
    .rst_out   (rst_out),
    .osc_en    (osc_en),
    .lvd_irq   (lvd_irq),
    .cause_lvd (cause_lvd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int len, input int cause, input string req);
    exp_t e;
    e.len = len;
    e.cause = cause;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release(input string req);
    int k;
    k = 0;
    while (rst_out !== 1'b0 && k < 400) begin
      @(posedge clk);
      #2;
      k++;
    end
    chk(req, "release seen", int'(k < 400), 1);
  endtask

  // Monitor: counts good cycles spent in reset and compares each release.
  initial begin
    int  run;
    bit  prev_high;
    bit  good;
    exp_t e;
    run = 0;
    prev_high = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      good = rst_n && por_ok && !(lvd_mode == 2'b11 && !lvd_ok);
      if (rst_out === 1'b1) begin
        if (good) run++;
        else run = 0;
        prev_high = 1'b1;
      end else if (prev_high) begin
        prev_high = 1'b0;
        if (exp_q.size() == 0) begin
          chk("R3", "unexpected release", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(e.req, "release length", run + 1, e.len);
          chk("R7", "cause at release", int'(cause_lvd), e.cause);
          chk("R2", "osc_en after release", int'(osc_en), 1);
        end
        run = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    por_ok = 1'b1;
    lvd_ok = 1'b1;
    lvd_mode = 2'b11;
    cycles(3);
    #1;
    // R1: reset state
    chk("R1", "rst_out in reset", int'(rst_out), 1);
    chk("R1", "osc_en in reset", int'(osc_en), 0);
    @(negedge clk);
    push(POR_C + LVD_C, 0, "R3");
    rst_n = 1'b1;
    #1;
    chk("R1", "lvd_irq after reset", int'(lvd_irq), 0);
    chk("R1", "cause after reset", int'(cause_lvd), 0);
    wait_release("R3");
    cycles(3);

    // R5: low-voltage dip in reset mode
    @(negedge clk);
    lvd_ok = 1'b0;
    #1;
    chk("R5", "rst_out same cycle", int'(rst_out), 1);
    chk("R2", "osc_en stopped", int'(osc_en), 0);
    cycles(4);
    push(LVD_C, 1, "R5");
    lvd_ok = 1'b1;
    wait_release("R5");
    cycles(5);
    #1;
    chk("R7", "cause held while running", int'(cause_lvd), 1);

    // R6: restart inside the low-voltage wait
    @(negedge clk);
    lvd_ok = 1'b0;
    cycles(2);
    lvd_ok = 1'b1;
    cycles(3);
    lvd_ok = 1'b0;
    cycles(2);
    push(LVD_C, 1, "R6");
    lvd_ok = 1'b1;
    wait_release("R6");
    cycles(2);

    // R6: restart inside the power-on wait
    @(negedge clk);
    por_ok = 1'b0;
    cycles(3);
    por_ok = 1'b1;
    cycles(10);
    por_ok = 1'b0;
    cycles(2);
    push(POR_C + LVD_C, 0, "R6");
    por_ok = 1'b1;
    wait_release("R6");
    cycles(2);

    // R4: interrupt mode power-on needs only the power-on wait
    @(negedge clk);
    lvd_mode = 2'b01;
    por_ok = 1'b0;
    cycles(3);
    push(POR_C, 0, "R4");
    por_ok = 1'b1;
    wait_release("R4");
    cycles(2);

    // R8: interrupt pulse
    @(negedge clk);
    lvd_ok = 1'b0;
    #1;
    chk("R8", "no reset same cycle", int'(rst_out), 0);
    @(posedge clk);
    #1;
    chk("R8", "pulse high", int'(lvd_irq), 1);
    chk("R8", "no reset during pulse", int'(rst_out), 0);
    @(posedge clk);
    #1;
    chk("R8", "pulse one cycle", int'(lvd_irq), 0);
    cycles(3);
    #1;
    chk("R8", "no repeat while low", int'(lvd_irq), 0);
    @(negedge clk);
    lvd_ok = 1'b1;
    cycles(2);

    // R9: detector ignored in modes 00 and 10
    for (int m = 0; m < 2; m++) begin
      int seen_rst;
      int seen_irq;
      @(negedge clk);
      lvd_mode = (m == 0) ? 2'b00 : 2'b10;
      lvd_ok = 1'b0;
      seen_rst = 0;
      seen_irq = 0;
      for (int i = 0; i < 5; i++) begin
        @(posedge clk);
        #1;
        if (rst_out) seen_rst = 1;
        if (lvd_irq) seen_irq = 1;
      end
      chk("R9", "no reset when ignored", seen_rst, 0);
      chk("R9", "no irq when ignored", seen_irq, 0);
      @(negedge clk);
      lvd_ok = 1'b1;
      cycles(2);
    end

    // R4: mode 10 power-on, then back to reset mode for a full event
    @(negedge clk);
    por_ok = 1'b0;
    cycles(2);
    push(POR_C, 0, "R4");
    por_ok = 1'b1;
    wait_release("R4");
    @(negedge clk);
    lvd_mode = 2'b11;
    lvd_ok = 1'b0;
    cycles(2);
    push(LVD_C, 1, "R7");
    lvd_ok = 1'b1;
    wait_release("R7");
    @(negedge clk);
    por_ok = 1'b0;
    cycles(2);
    push(POR_C + LVD_C, 0, "R7");
    por_ok = 1'b1;
    wait_release("R7");
    cycles(3);

    chk("R3", "scoreboard drained", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule